// File: doc/BRIEF.md
# Frame Scrubbing Controller

This controller walks a memory of fixed-size frames and repairs upsets in place. It fetches each frame word by word into a local buffer. Then it waits for an external checker to report a syndrome for that frame. When the syndrome shows a single flipped bit inside the frame, the controller inverts that bit in the buffer and writes the whole frame back to the address it came from. When the syndrome shows a double error, or points at a bit outside the data, the controller fetches a pristine copy of the frame from a golden store and writes that copy back. After any write-back the controller reads the frame again, so that a repair that did not hold raises a sticky fault. Scanning then carries on at the next frame.

The frame memory and the golden store are each reached through a request channel with valid/ready and a response channel with valid only. The requester holds a request and its whole payload steady while valid is high and ready is low. Only one request is outstanding at a time, and responses come back in order. The controller always accepts a response, so the response channels have no ready. The checker provides a one-cycle strobe with a syndrome word. The top bit of that word marks a single error, and the low bits give the flat bit position: word index times DW plus bit index. The controller samples the strobe only while it is waiting for a syndrome.

Top module: `scrub_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, busy, fault, both counters, all request valids and the write enable are 0.
- R2: A start pulse seen while idle begins a scan at frame 0. Each frame is read with word requests 0 to WORDS-1 in order, one at a time. A start pulse while busy has no effect.
- R3: While a request valid is high and its ready is low, the valid stays high and the frame, word, write-enable and write-data fields stay unchanged on the next cycle.
- R4: A syndrome with all low bits zero (whatever the top bit) causes no write and no golden read. The scan moves to the next frame.
- R5: A syndrome with top bit 1 and low index below WORDS*DW inverts bit (index mod DW) of word (index / DW), with DW a power of two. The controller writes all words back to the same frame in order 0 to WORDS-1 and adds one to the single-fix counter.
- R6: A syndrome with top bit 0 and nonzero low bits, or with top bit 1 and an index at or above WORDS*DW, reads all words of the frame from the golden store in order. It writes them back to the same frame and adds one to the restore counter.
- R7: After every write-back the frame is read again and a syndrome is awaited. A nonzero syndrome sets the fault flag, which stays set until reset.
- R8: After the last frame the scan ends and busy falls if one-shot mode is set. Otherwise the scan wraps to frame 0. No request is issued while busy is low.
- R9: The frame-memory and golden-store requests are never valid in the same cycle, and the counters only ever hold or step by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan at frame 0 when idle |
| one_shot | input | 1 | Stop after the last frame instead of wrapping |
| busy | output | 1 | Scan in progress |
| fault | output | 1 | Sticky: a re-read after write-back still showed an error |
| cnt_single | output | CNT_W | Count of in-place single-bit fixes |
| cnt_restore | output | CNT_W | Count of frames restored from the golden store |
| mem_req_valid | output | 1 | Frame-memory request valid |
| mem_req_ready | input | 1 | Frame-memory request accepted |
| mem_req_we | output | 1 | 1 for write, 0 for read |
| mem_req_frame | output | FA_W | Frame address |
| mem_req_word | output | WI_W | Word index within the frame |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DW | Read data |
| gold_req_valid | output | 1 | Golden-store read request valid |
| gold_req_ready | input | 1 | Golden-store request accepted |
| gold_req_frame | output | FA_W | Golden frame address |
| gold_req_word | output | WI_W | Golden word index |
| gold_rsp_valid | input | 1 | Golden read data valid |
| gold_rsp_data | input | DW | Golden read data |
| syn_valid | input | 1 | Syndrome strobe for the frame just read |
| syn_value | input | IDX_W+1 | Syndrome: top bit single flag, low bits flat bit index |

## Verification
On every cycle the assertions check the hold rule for a stalled request, the exclusion between the two request channels, that no request appears while idle, the reset values, that the fault flag never clears, and that the counters only step by one. Only the bench's scenarios can show which repair a syndrome selects and that the flipped bit lands at the right word and position. They also show that clean frames cause no writes, that a repair which does not hold is caught by the re-read, and that the scan stops or wraps after the last frame. The bench does this by matching every handshake against an expected operation queue and by comparing the final memory image.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_MRD_REQ,
    ST_MRD_RSP,
    ST_SYN_WAIT,
    ST_DECIDE,
    ST_GRD_REQ,
    ST_GRD_RSP,
    ST_MWR_REQ,
    ST_NEXT
  } scrub_state_e;

  typedef enum logic [1:0] {
    ACT_KEEP,
    ACT_FLIP,
    ACT_RESTORE
  } scrub_act_e;

endpackage

// File: rtl/scrub_frame_buf.sv
module scrub_frame_buf #(
  parameter int WORDS = 3,
  parameter int DW    = 32,
  localparam int WI_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BIT_W = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WI_W-1:0]  wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             flip_en,
  input  logic [WI_W-1:0]  flip_idx,
  input  logic [BIT_W-1:0] flip_bit,
  input  logic [WI_W-1:0]  rd_idx,
  output logic [DW-1:0]    rd_data
);

  logic [DW-1:0] slot_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (wr_en && wr_idx == WI_W'(g)) begin
        slot_q[g] <= wr_data;
      end else if (flip_en && flip_idx == WI_W'(g)) begin
        slot_q[g] <= slot_q[g] ^ (DW'(1) << flip_bit);
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (rd_idx == WI_W'(i)) rd_data = slot_q[i];
    end
  end

endmodule

// File: rtl/scrub_syn_decode.sv
module scrub_syn_decode
  import scrub_pkg::*;
#(
  parameter int WORDS = 3,
  parameter int DW    = 32,
  localparam int WI_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BIT_W = (DW > 1) ? $clog2(DW) : 1,
  localparam int IDX_W = $clog2(WORDS * DW),
  localparam int SYN_W = IDX_W + 1
) (
  input  logic [SYN_W-1:0] syn,
  output scrub_act_e       act,
  output logic [WI_W-1:0]  word,
  output logic [BIT_W-1:0] bitpos
);

  localparam int BITS = WORDS * DW;

  logic [IDX_W-1:0] idx;
  logic             single_flag;
  logic             in_range;

  assign idx         = syn[IDX_W-1:0];
  assign single_flag = syn[SYN_W-1];
  assign in_range    = (32'(idx) < BITS);
  assign word        = WI_W'(idx >> BIT_W);
  assign bitpos      = BIT_W'(idx);

  always_comb begin
    if (idx == '0)                     act = ACT_KEEP;
    else if (single_flag && in_range)  act = ACT_FLIP;
    else                               act = ACT_RESTORE;
  end

endmodule

// File: rtl/scrub_frame_walk.sv
module scrub_frame_walk #(
  parameter int FRAMES = 8,
  localparam int FA_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            advance,
  output logic [FA_W-1:0] frame,
  output logic            at_last
);

  localparam logic [FA_W-1:0] LAST = FA_W'(FRAMES - 1);

  assign at_last = (frame == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frame <= '0;
    else if (restart)  frame <= '0;
    else if (advance)  frame <= at_last ? '0 : frame + 1'b1;
  end

endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
  import scrub_pkg::*;
#(
  parameter int FRAMES = 8,
  parameter int WORDS  = 3,
  parameter int DW     = 32,
  parameter int CNT_W  = 16,
  localparam int FA_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int WI_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BIT_W = (DW > 1) ? $clog2(DW) : 1,
  localparam int IDX_W = $clog2(WORDS * DW),
  localparam int SYN_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             one_shot,
  output logic             busy,
  output logic             fault,
  output logic [CNT_W-1:0] cnt_single,
  output logic [CNT_W-1:0] cnt_restore,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [FA_W-1:0]  mem_req_frame,
  output logic [WI_W-1:0]  mem_req_word,
  output logic [DW-1:0]    mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [DW-1:0]    mem_rsp_data,
  output logic             gold_req_valid,
  input  logic             gold_req_ready,
  output logic [FA_W-1:0]  gold_req_frame,
  output logic [WI_W-1:0]  gold_req_word,
  input  logic             gold_rsp_valid,
  input  logic [DW-1:0]    gold_rsp_data,
  input  logic             syn_valid,
  input  logic [SYN_W-1:0] syn_value
);

  localparam logic [WI_W-1:0] LAST_WORD = WI_W'(WORDS - 1);

  scrub_state_e     state_q, state_d;
  logic [WI_W-1:0]  word_q, word_d;
  logic             verify_q, verify_d;
  logic [SYN_W-1:0] syn_q;
  logic             fault_q, fault_d;
  logic [CNT_W-1:0] single_q, restore_q;
  logic             inc_single, inc_restore;

  logic [FA_W-1:0]  frame;
  logic             at_last;
  logic             walk_restart, walk_advance;

  logic             buf_wr_en;
  logic [DW-1:0]    buf_wr_data;
  logic             buf_flip_en;
  logic [DW-1:0]    buf_rd_data;

  scrub_act_e       act;
  logic [WI_W-1:0]  flip_word;
  logic [BIT_W-1:0] flip_bit;

  scrub_frame_walk #(.FRAMES(FRAMES)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (walk_restart),
    .advance (walk_advance),
    .frame   (frame),
    .at_last (at_last)
  );

  scrub_syn_decode #(.WORDS(WORDS), .DW(DW)) u_dec (
    .syn    (syn_q),
    .act    (act),
    .word   (flip_word),
    .bitpos (flip_bit)
  );

  scrub_frame_buf #(.WORDS(WORDS), .DW(DW)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (buf_wr_en),
    .wr_idx   (word_q),
    .wr_data  (buf_wr_data),
    .flip_en  (buf_flip_en),
    .flip_idx (flip_word),
    .flip_bit (flip_bit),
    .rd_idx   (word_q),
    .rd_data  (buf_rd_data)
  );

  // buffer fill from whichever source is answering
  assign buf_wr_en   = (state_q == ST_MRD_RSP && mem_rsp_valid) ||
                       (state_q == ST_GRD_RSP && gold_rsp_valid);
  assign buf_wr_data = (state_q == ST_GRD_RSP) ? gold_rsp_data : mem_rsp_data;

  // request channels are pure functions of state
  assign mem_req_valid  = (state_q == ST_MRD_REQ) || (state_q == ST_MWR_REQ);
  assign mem_req_we     = (state_q == ST_MWR_REQ);
  assign mem_req_frame  = frame;
  assign mem_req_word   = word_q;
  assign mem_req_wdata  = buf_rd_data;
  assign gold_req_valid = (state_q == ST_GRD_REQ);
  assign gold_req_frame = frame;
  assign gold_req_word  = word_q;

  assign busy        = (state_q != ST_IDLE);
  assign fault       = fault_q;
  assign cnt_single  = single_q;
  assign cnt_restore = restore_q;

  always_comb begin
    state_d      = state_q;
    word_d       = word_q;
    verify_d     = verify_q;
    fault_d      = fault_q;
    inc_single   = 1'b0;
    inc_restore  = 1'b0;
    buf_flip_en  = 1'b0;
    walk_restart = 1'b0;
    walk_advance = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          walk_restart = 1'b1;
          word_d       = '0;
          verify_d     = 1'b0;
          state_d      = ST_MRD_REQ;
        end
      end
      ST_MRD_REQ: begin
        if (mem_req_ready) state_d = ST_MRD_RSP;
      end
      ST_MRD_RSP: begin
        if (mem_rsp_valid) begin
          if (word_q == LAST_WORD) begin
            word_d  = '0;
            state_d = ST_SYN_WAIT;
          end else begin
            word_d  = word_q + 1'b1;
            state_d = ST_MRD_REQ;
          end
        end
      end
      ST_SYN_WAIT: begin
        if (syn_valid) state_d = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (verify_q) begin
          if (syn_q != '0) fault_d = 1'b1;
          verify_d = 1'b0;
          state_d  = ST_NEXT;
        end else begin
          unique case (act)
            ACT_FLIP: begin
              buf_flip_en = 1'b1;
              inc_single  = 1'b1;
              word_d      = '0;
              state_d     = ST_MWR_REQ;
            end
            ACT_RESTORE: begin
              inc_restore = 1'b1;
              word_d      = '0;
              state_d     = ST_GRD_REQ;
            end
            default: state_d = ST_NEXT;
          endcase
        end
      end
      ST_GRD_REQ: begin
        if (gold_req_ready) state_d = ST_GRD_RSP;
      end
      ST_GRD_RSP: begin
        if (gold_rsp_valid) begin
          if (word_q == LAST_WORD) begin
            word_d  = '0;
            state_d = ST_MWR_REQ;
          end else begin
            word_d  = word_q + 1'b1;
            state_d = ST_GRD_REQ;
          end
        end
      end
      ST_MWR_REQ: begin
        if (mem_req_ready) begin
          if (word_q == LAST_WORD) begin
            word_d   = '0;
            verify_d = 1'b1;
            state_d  = ST_MRD_REQ;
          end else begin
            word_d = word_q + 1'b1;
          end
        end
      end
      ST_NEXT: begin
        word_d = '0;
        if (at_last && one_shot) begin
          state_d = ST_IDLE;
        end else begin
          walk_advance = 1'b1;
          state_d      = ST_MRD_REQ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      word_q    <= '0;
      verify_q  <= 1'b0;
      syn_q     <= '0;
      fault_q   <= 1'b0;
      single_q  <= '0;
      restore_q <= '0;
    end else begin
      state_q  <= state_d;
      word_q   <= word_d;
      verify_q <= verify_d;
      fault_q  <= fault_d;
      if (state_q == ST_SYN_WAIT && syn_valid) syn_q <= syn_value;
      if (inc_single)  single_q  <= single_q + 1'b1;
      if (inc_restore) restore_q <= restore_q + 1'b1;
    end
  end

endmodule

// File: rtl/scrub_ctrl_chk.sv
module scrub_ctrl_chk #(
  parameter int FA_W  = 3,
  parameter int WI_W  = 2,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             fault,
  input logic [CNT_W-1:0] cnt_single,
  input logic [CNT_W-1:0] cnt_restore,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_we,
  input logic [FA_W-1:0]  mem_req_frame,
  input logic [WI_W-1:0]  mem_req_word,
  input logic [DW-1:0]    mem_req_wdata,
  input logic             gold_req_valid,
  input logic             gold_req_ready,
  input logic [FA_W-1:0]  gold_req_frame,
  input logic [WI_W-1:0]  gold_req_word
);

  // R1
  reset_values_chk: assert property (@(posedge clk)
    !rst_n |=> (!busy && !fault && cnt_single == '0 && cnt_restore == '0 &&
                !mem_req_valid && !gold_req_valid && !mem_req_we));

  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_we) && $stable(mem_req_frame) &&
      $stable(mem_req_word) && $stable(mem_req_wdata));

  // R3
  gold_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gold_req_valid && !gold_req_ready |=>
      gold_req_valid && $stable(gold_req_frame) && $stable(gold_req_word));

  // R7
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || gold_req_valid) |-> busy);

  // R9
  one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && gold_req_valid));

  // R9
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_single == $past(cnt_single) ||
              cnt_single == $past(cnt_single) + 1'b1));

  // R9
  restore_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_restore == $past(cnt_restore) ||
              cnt_restore == $past(cnt_restore) + 1'b1));

endmodule

bind scrub_ctrl scrub_ctrl_chk #(
  .FA_W(FA_W), .WI_W(WI_W), .DW(DW), .CNT_W(CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy           (busy),
  .fault          (fault),
  .cnt_single     (cnt_single),
  .cnt_restore    (cnt_restore),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_we     (mem_req_we),
  .mem_req_frame  (mem_req_frame),
  .mem_req_word   (mem_req_word),
  .mem_req_wdata  (mem_req_wdata),
  .gold_req_valid (gold_req_valid),
  .gold_req_ready (gold_req_ready),
  .gold_req_frame (gold_req_frame),
  .gold_req_word  (gold_req_word)
);

// File: tb/tb_scrub_ctrl.sv
module tb_scrub_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int FRAMES = 8;
  localparam int WORDS  = 3;
  localparam int DW     = 32;
  localparam int CNT_W  = 16;
  localparam int FA_W   = 3;
  localparam int WI_W   = 2;
  localparam int SYN_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, one_shot = 1'b1;
  logic busy, fault;
  logic [CNT_W-1:0] cnt_single, cnt_restore;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_req_we;
  logic [FA_W-1:0] mem_req_frame;
  logic [WI_W-1:0] mem_req_word;
  logic [DW-1:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic gold_req_valid, gold_req_ready = 1'b0;
  logic [FA_W-1:0] gold_req_frame;
  logic [WI_W-1:0] gold_req_word;
  logic gold_rsp_valid = 1'b0;
  logic [DW-1:0] gold_rsp_data = '0;
  logic syn_valid = 1'b0;
  logic [SYN_W-1:0] syn_value = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scrub_ctrl #(.FRAMES(FRAMES), .WORDS(WORDS), .DW(DW), .CNT_W(CNT_W)) dut (.*);

  int total = 0, bad = 0;

  // behavioural memories
  logic [DW-1:0] mem  [FRAMES][WORDS];
  logic [DW-1:0] gold [FRAMES][WORDS];
  logic [DW-1:0] stuck[FRAMES][WORDS];
  logic          ovr_on [FRAMES];
  logic [SYN_W-1:0] ovr_val [FRAMES];

  // expected handshake queue: kind 0 mem read, 1 gold read, 2 mem write
  typedef struct {
    int kind; int frame; int word; logic [DW-1:0] data; string tag;
  } op_t;
  op_t q[$];

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp,
                     input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input int f, input int w, input string tag);
    op_t o;
    o.kind = kind; o.frame = f; o.word = w; o.data = gold[f][w]; o.tag = tag;
    q.push_back(o);
  endtask

  // cls: 0 clean, 1 single flip, 2 restore
  task automatic push_frame(input int f, input int cls);
    for (int w = 0; w < WORDS; w++) push(0, f, w, "R2");
    if (cls != 0) begin
      if (cls == 2) for (int w = 0; w < WORDS; w++) push(1, f, w, "R6");
      for (int w = 0; w < WORDS; w++) push(2, f, w, (cls == 1) ? "R5" : "R6");
      for (int w = 0; w < WORDS; w++) push(0, f, w, "R7");
    end
  endtask

  function automatic logic [SYN_W-1:0] calc_syn(input int f);
    int n = 0, i1 = 0, i2 = 0;
    for (int w = 0; w < WORDS; w++)
      for (int b = 0; b < DW; b++)
        if (mem[f][w][b] !== gold[f][w][b]) begin
          if (n == 0) i1 = w * DW + b; else i2 = w * DW + b;
          n++;
        end
    if (n == 0) return '0;
    if (n == 1) return {1'b1, 7'(i1)};
    return {1'b0, 7'(i1 ^ i2)};
  endfunction

  function automatic void apply_op(input int kind, input int f, input int w, input string why);
    op_t o;
    string tag;
    if (q.size() == 0) begin
      total++; bad++;
      $display("FAIL R4 unexpected op kind=%0d frame=%0d word=%0d: actual=op expected=none",
               kind, f, w);
      return;
    end
    o = q.pop_front();
    tag = o.tag;
    total++;
    if (o.kind != kind || o.frame != f || o.word != w) begin
      bad++;
      $display("FAIL %s op %s: actual=k%0d f%0d w%0d expected=k%0d f%0d w%0d",
               tag, why, kind, f, w, o.kind, o.frame, o.word);
    end
  endfunction

  // memory, golden store and checker models
  logic [7:0] lf = 8'hA5;
  bit m_pend = 0, g_pend = 0;
  int pf = 0, pw = 0, gf = 0, gw = 0, syn_cnt = 0;
  logic [SYN_W-1:0] syn_hold = '0;
  bit m_stall = 0, g_stall = 0;
  logic [FA_W+WI_W+DW:0] m_hold = '0;
  logic [FA_W+WI_W-1:0] g_hold = '0;

  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0; gold_rsp_valid = 1'b0; syn_valid = 1'b0;
      if (syn_cnt > 0) begin
        syn_cnt--;
        if (syn_cnt == 0) begin syn_valid = 1'b1; syn_value = syn_hold; end
      end
      if (m_pend) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = mem[pf][pw]; m_pend = 0;
        if (pw == WORDS - 1) begin
          syn_hold = calc_syn(pf);
          if (ovr_on[pf]) begin syn_hold = ovr_val[pf]; ovr_on[pf] = 1'b0; end
          syn_cnt = 2;
        end
      end
      if (g_pend) begin
        gold_rsp_valid = 1'b1; gold_rsp_data = gold[gf][gw]; g_pend = 0;
      end
      if (rst_n && m_stall)
        chk("R3", mem_req_valid && {mem_req_we, mem_req_frame, mem_req_word, mem_req_wdata} == m_hold,
            {mem_req_frame, mem_req_word}, m_hold[DW+WI_W+FA_W-1:DW], "mem request held");
      if (rst_n && g_stall)
        chk("R3", gold_req_valid && {gold_req_frame, gold_req_word} == g_hold,
            {gold_req_frame, gold_req_word}, g_hold, "gold request held");
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      mem_req_ready  = lf[0] | lf[2];
      gold_req_ready = lf[1] | lf[6];
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          apply_op(2, int'(mem_req_frame), int'(mem_req_word), "write");
          if (q.size() >= 0 && mem_req_wdata !== gold[mem_req_frame][mem_req_word]) begin
            total++; bad++;
            $display("FAIL R5 write data f%0d w%0d: actual=%0h expected=%0h", mem_req_frame,
                     mem_req_word, mem_req_wdata, gold[mem_req_frame][mem_req_word]);
          end
          mem[mem_req_frame][mem_req_word] =
            (mem_req_wdata & ~stuck[mem_req_frame][mem_req_word]) |
            (mem[mem_req_frame][mem_req_word] & stuck[mem_req_frame][mem_req_word]);
        end else begin
          apply_op(0, int'(mem_req_frame), int'(mem_req_word), "read");
          m_pend = 1; pf = int'(mem_req_frame); pw = int'(mem_req_word);
        end
      end
      if (rst_n && gold_req_valid && gold_req_ready) begin
        apply_op(1, int'(gold_req_frame), int'(gold_req_word), "gold read");
        g_pend = 1; gf = int'(gold_req_frame); gw = int'(gold_req_word);
      end
      m_stall = mem_req_valid && !mem_req_ready;
      m_hold  = {mem_req_we, mem_req_frame, mem_req_word, mem_req_wdata};
      g_stall = gold_req_valid && !gold_req_ready;
      g_hold  = {gold_req_frame, gold_req_word};
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    chk("R8", !busy, busy, 0, "scan finished");
  endtask

  task automatic check_image();
    for (int f = 0; f < FRAMES; f++)
      for (int w = 0; w < WORDS; w++)
        chk("R6", mem[f][w] === (gold[f][w] ^ stuck[f][w]), mem[f][w],
            gold[f][w] ^ stuck[f][w], $sformatf("image f%0d w%0d", f, w));
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    for (int f = 0; f < FRAMES; f++) begin
      ovr_on[f] = 1'b0; ovr_val[f] = '0;
      for (int w = 0; w < WORDS; w++) begin
        gold[f][w]  = (32'h9E37_79B9 * (f * WORDS + w + 1)) ^ 32'h5A5A_0F0F;
        mem[f][w]   = gold[f][w];
        stuck[f][w] = '0;
      end
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", !busy && !fault && !mem_req_valid && !gold_req_valid, busy, 0, "idle in reset");
    chk("R1", cnt_single == 0 && cnt_restore == 0, cnt_single, 0, "counters in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", !busy && !mem_req_valid, busy, 0, "idle after reset");

    // scenario 1: one pass with single, double and out-of-range faults
    mem[1][2][5]  ^= 1'b1;
    mem[3][0][1]  ^= 1'b1;
    mem[3][1][30] ^= 1'b1;
    mem[5][0][31] ^= 1'b1;
    ovr_on[6] = 1'b1; ovr_val[6] = {1'b1, 7'd100};
    ovr_on[0] = 1'b1; ovr_val[0] = {1'b1, 7'd0};   // R4: top bit only, keep
    push_frame(0, 0); push_frame(1, 1); push_frame(2, 0); push_frame(3, 2);
    push_frame(4, 0); push_frame(5, 1); push_frame(6, 2); push_frame(7, 0);
    one_shot = 1'b1;
    pulse_start();
    chk("R2", busy, busy, 1, "busy after start");
    repeat (40) @(negedge clk);
    pulse_start();   // R2: ignored while busy
    wait_idle();
    chk("R4", q.size() == 0, q.size(), 0, "all expected ops seen, none extra");
    chk("R5", cnt_single == 2, cnt_single, 2, "single fixes after pass 1");
    chk("R6", cnt_restore == 2, cnt_restore, 2, "restores after pass 1");
    chk("R7", !fault, fault, 0, "no fault after good repairs");
    check_image();

    // scenario 2: continuous mode wraps, then one-shot ends it
    mem[2][1][17] ^= 1'b1;
    for (int f = 0; f < FRAMES; f++) push_frame(f, (f == 2) ? 1 : 0);
    for (int f = 0; f < FRAMES; f++) push_frame(f, 0);
    one_shot = 1'b0;
    pulse_start();
    begin
      int n = 0;
      while (q.size() > FRAMES * WORDS - 1 && n < 20000) begin @(negedge clk); n++; end
    end
    chk("R8", busy && q.size() == FRAMES * WORDS - 1, q.size(), FRAMES * WORDS - 1,
        "wrapped to frame 0");
    one_shot = 1'b1;
    wait_idle();
    chk("R8", q.size() == 0, q.size(), 0, "second pass complete");
    chk("R5", cnt_single == 3, cnt_single, 3, "single fixes after pass 2");
    check_image();

    // scenario 3: stuck bit defeats repair, fault must latch and stay
    chk("R7", !fault, fault, 0, "fault clear before stuck test");
    stuck[4][1] = 32'h0000_0080;
    mem[4][1][7] ^= 1'b1;
    for (int f = 0; f < FRAMES; f++) push_frame(f, (f == 4) ? 1 : 0);
    pulse_start();
    wait_idle();
    chk("R7", fault, fault, 1, "fault after failed repair");
    chk("R5", cnt_single == 4, cnt_single, 4, "single count with stuck bit");
    chk("R6", cnt_restore == 2, cnt_restore, 2, "restore count unchanged");
    chk("R4", q.size() == 0, q.size(), 0, "ops complete pass 3");
    check_image();
    repeat (20) @(negedge clk);
    chk("R7", fault, fault, 1, "fault stays set");
    chk("R8", !busy && !mem_req_valid, busy, 0, "quiet when idle");
    summary();
  end

endmodule